// File: doc/BRIEF.md
# Serial-Loaded Bank Register Controller

This block holds the banking state of a cartridge-style memory controller. The processor programs it over a one-bit-wide path. Each write to the upper half of the processor address space delivers a single data bit. Five such writes make up one 5-bit value, and that value lands in one of four destinations chosen by the address of the last write. A write with the top data bit set cancels a partial sequence and forces the program-banking mode bits high.

The outputs are the current control value, the nametable mirroring mode, three character-memory bank numbers (two 4 KB halves and one 8 KB window) and three program-memory bank numbers (a low and a high 16 KB window and one 32 KB window). A downstream address translator uses these outputs directly. The total number of 16 KB program banks arrives on an input, so the block can place the last bank in the fixed high window.

Top module: `serial_bank_ctrl`

## Requirements
- R1: A write whose address has bit 15 clear has no effect at all. Writes in 0x6000–0x7FFF do not shift a bit, do not advance the write count and do not trigger the escape, even when data bit 7 is set.
- R2: A qualifying write with data bit 7 set discards any partial sequence, so the next five bit-writes form a fresh value. It also sets control bits 3:2 to 1 and leaves the other control bits unchanged.
- R3: Each qualifying write with data bit 7 clear supplies data bit 0 as the next value bit, least significant bit first. Nothing is committed before the fifth bit-write.
- R4: The destination is taken from address bits 14:13 of the fifth write only: 0 is control, 1 is the first character select, 2 is the second character select and 3 is program select. After the commit a new five-write sequence starts.
- R5: The control value resets to 0x1C, and a commit to destination 0 replaces all five of its bits.
- R6: The mirroring output equals control bits 1:0, encoded as 0 for one-screen low, 1 for one-screen high, 2 for vertical and 3 for horizontal.
- R7: A commit to destination 1 works in one of two ways. With control bit 4 set, it loads the low 4 KB character bank with the whole value. With control bit 4 clear, it loads the 8 KB character bank with the value with bit 0 forced to 0.
- R8: A commit to destination 2 loads the high 4 KB character bank when control bit 4 is set. With the bit clear, it changes nothing.
- R9: A commit to destination 3 while control bits 3:2 are 0 or 1 loads the 32 KB program bank with value bits 3:1.
- R10: A commit to destination 3 while control bits 3:2 are 2 clears the low 16 KB bank and loads the high 16 KB bank with value bits 3:0.
- R11: A commit to destination 3 while control bits 3:2 are 3 loads the low 16 KB bank with value bits 3:0 and sets the high 16 KB bank to the bank count minus one.
- R12: At reset (synchronous, active low) the high 16 KB bank equals the bank count minus one, and every other bank number is 0.
- R13: A write strobe that stays high for several clocks counts as one write. Only its rising edge is acted on, and outputs change on the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | Processor address of the write |
| cpu_wdata | input | 8 | Processor write data |
| cpu_we | input | 1 | Write strobe, level; its rising edge is one write |
| prg_bank_count | input | 5 | Number of 16 KB program banks |
| ctrl_q | output | 5 | Current control value |
| mirror_mode | output | 2 | Mirroring mode (0 one-screen low, 1 one-screen high, 2 vertical, 3 horizontal) |
| chr_lo4k | output | 5 | Character bank for the lower 4 KB half |
| chr_hi4k | output | 5 | Character bank for the upper 4 KB half |
| chr_8k | output | 5 | Character bank for the 8 KB window (bit 0 always 0) |
| prg_lo16k | output | 4 | Program bank for the low 16 KB window |
| prg_hi16k | output | 4 | Program bank for the high 16 KB window |
| prg_32k | output | 3 | Program bank for the 32 KB window |

## Verification
The hardest situations to reach are those where the hidden five-write count is corrupted: low-address writes, including an escape-looking one, placed inside a half-finished sequence, an escape arriving after two bits, and a sequence whose fifth write carries a different destination address than the first four. The stimulus builds these by splitting a value's bit-writes by hand. It then watches the port where the commit lands, checking both just before and just after the write that should complete it. Multi-cycle strobes are covered by repeating a whole load with the strobe held four clocks per write.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  // Width of one serially assembled value and of the write counter.
  localparam int SBC_VAL_W = 5;
  localparam int SBC_CNT_W = 3;

  typedef logic [SBC_VAL_W-1:0] sbc_val_t;

  // Mirroring encodings driven out on mirror_mode.
  typedef enum logic [1:0] {
    MIR_SINGLE_LO  = 2'd0,
    MIR_SINGLE_HI  = 2'd1,
    MIR_VERTICAL   = 2'd2,
    MIR_HORIZONTAL = 2'd3
  } sbc_mirror_e;

  // Commit destinations, decoded from address bits 14:13.
  typedef enum logic [1:0] {
    TGT_CTRL  = 2'd0,
    TGT_CHR_A = 2'd1,
    TGT_CHR_B = 2'd2,
    TGT_PRG   = 2'd3
  } sbc_target_e;

  localparam sbc_val_t SBC_CTRL_RESET = 5'h1C;
  localparam sbc_val_t SBC_ESC_MASK   = 5'h0C;

  // New bit enters at the top; older bits move toward bit 0.
  function automatic sbc_val_t sbc_shift_in(sbc_val_t cur, logic b);
    return {b, cur[SBC_VAL_W-1:1]};
  endfunction

  // 8 KB character bank numbers are always even.
  function automatic sbc_val_t sbc_even(sbc_val_t v);
    return {v[SBC_VAL_W-1:1], 1'b0};
  endfunction

  function automatic sbc_mirror_e sbc_mirror_of(sbc_val_t ctrl);
    sbc_mirror_e m;
    case (ctrl[1:0])
      2'd0:    m = MIR_SINGLE_LO;
      2'd1:    m = MIR_SINGLE_HI;
      2'd2:    m = MIR_VERTICAL;
      default: m = MIR_HORIZONTAL;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/sbc_serial_loader.sv
module sbc_serial_loader
  import sbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic [DATA_W-1:0]    cpu_wdata,
  input  logic                 cpu_we,
  output logic                 accept,
  output logic                 escape,
  output logic                 commit,
  output sbc_target_e          commit_tgt,
  output sbc_val_t             commit_val,
  output logic [SBC_CNT_W-1:0] fill_cnt
);

  localparam logic [SBC_CNT_W-1:0] LAST_IDX = SBC_CNT_W'(SBC_VAL_W - 1);

  logic                 we_q;
  sbc_val_t             shift_q;
  logic [SBC_CNT_W-1:0] cnt_q;
  logic                 esc_bit;

  // One write per rising strobe edge, upper address half only.
  assign accept     = cpu_we && !we_q && cpu_addr[ADDR_W-1];
  assign esc_bit    = cpu_wdata[DATA_W-1];
  assign escape     = accept && esc_bit;
  assign commit     = accept && !esc_bit && (cnt_q == LAST_IDX);
  assign commit_val = sbc_shift_in(shift_q, cpu_wdata[0]);
  assign commit_tgt = sbc_target_e'(cpu_addr[ADDR_W-2 -: 2]);
  assign fill_cnt   = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      shift_q <= '0;
      cnt_q   <= '0;
    end else begin
      we_q <= cpu_we;
      if (escape || commit) begin
        shift_q <= '0;
        cnt_q   <= '0;
      end else if (accept) begin
        shift_q <= commit_val;
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sbc_bank_regs.sv
module sbc_bank_regs
  import sbc_pkg::*;
#(
  parameter int PRG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             escape,
  input  logic             commit,
  input  sbc_target_e      commit_tgt,
  input  sbc_val_t         commit_val,
  input  logic [PRG_W:0]   prg_bank_count,
  output sbc_val_t         ctrl_q,
  output sbc_val_t         chr_lo4k,
  output sbc_val_t         chr_hi4k,
  output sbc_val_t         chr_8k,
  output logic [PRG_W-1:0] prg_lo16k,
  output logic [PRG_W-1:0] prg_hi16k,
  output logic [PRG_W-2:0] prg_32k,
  output logic [PRG_W-1:0] last_bank
);

  // Bank count minus one, truncated to a bank number.
  function automatic logic [PRG_W-1:0] last_of(logic [PRG_W:0] count);
    logic [PRG_W:0] d;
    d = count - 1'b1;
    return d[PRG_W-1:0];
  endfunction

  function automatic logic [PRG_W-1:0] bank16_of(sbc_val_t v);
    return v[PRG_W-1:0];
  endfunction

  function automatic logic [PRG_W-2:0] bank32_of(sbc_val_t v);
    return v[PRG_W-1:1];
  endfunction

  logic       chr_split;
  logic [1:0] prg_mode;

  assign last_bank = last_of(prg_bank_count);
  assign chr_split = ctrl_q[4];
  assign prg_mode  = ctrl_q[3:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= SBC_CTRL_RESET;
      chr_lo4k  <= '0;
      chr_hi4k  <= '0;
      chr_8k    <= '0;
      prg_lo16k <= '0;
      prg_hi16k <= last_bank;
      prg_32k   <= '0;
    end else if (escape) begin
      ctrl_q <= ctrl_q | SBC_ESC_MASK;
    end else if (commit) begin
      case (commit_tgt)
        TGT_CTRL: ctrl_q <= commit_val;
        TGT_CHR_A: begin
          if (chr_split) chr_lo4k <= commit_val;
          else           chr_8k   <= sbc_even(commit_val);
        end
        TGT_CHR_B: begin
          if (chr_split) chr_hi4k <= commit_val;
        end
        default: begin
          case (prg_mode)
            2'd2: begin
              prg_lo16k <= '0;
              prg_hi16k <= bank16_of(commit_val);
            end
            2'd3: begin
              prg_lo16k <= bank16_of(commit_val);
              prg_hi16k <= last_bank;
            end
            default: prg_32k <= bank32_of(commit_val);
          endcase
        end
      endcase
    end
  end

endmodule

// File: rtl/sbc_mirror_map.sv
module sbc_mirror_map
  import sbc_pkg::*;
(
  input  sbc_val_t    ctrl,
  output logic [1:0]  mode
);

  sbc_mirror_e m;

  always_comb begin
    m    = sbc_mirror_of(ctrl);
    mode = m;
  end

endmodule

// File: rtl/serial_bank_ctrl.sv
module serial_bank_ctrl
  import sbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PRG_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic [DATA_W-1:0]    cpu_wdata,
  input  logic                 cpu_we,
  input  logic [PRG_W:0]       prg_bank_count,
  output logic [SBC_VAL_W-1:0] ctrl_q,
  output logic [1:0]           mirror_mode,
  output logic [SBC_VAL_W-1:0] chr_lo4k,
  output logic [SBC_VAL_W-1:0] chr_hi4k,
  output logic [SBC_VAL_W-1:0] chr_8k,
  output logic [PRG_W-1:0]     prg_lo16k,
  output logic [PRG_W-1:0]     prg_hi16k,
  output logic [PRG_W-2:0]     prg_32k
);

  // Internal events, named so the bound checker can observe them.
  logic                 accept;
  logic                 escape;
  logic                 commit;
  sbc_target_e          commit_tgt;
  sbc_val_t             commit_val;
  logic [SBC_CNT_W-1:0] fill_cnt;
  logic [PRG_W-1:0]     last_bank;

  sbc_serial_loader #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_loader (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_we     (cpu_we),
    .accept     (accept),
    .escape     (escape),
    .commit     (commit),
    .commit_tgt (commit_tgt),
    .commit_val (commit_val),
    .fill_cnt   (fill_cnt)
  );

  sbc_bank_regs #(
    .PRG_W(PRG_W)
  ) u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .escape         (escape),
    .commit         (commit),
    .commit_tgt     (commit_tgt),
    .commit_val     (commit_val),
    .prg_bank_count (prg_bank_count),
    .ctrl_q         (ctrl_q),
    .chr_lo4k       (chr_lo4k),
    .chr_hi4k       (chr_hi4k),
    .chr_8k         (chr_8k),
    .prg_lo16k      (prg_lo16k),
    .prg_hi16k      (prg_hi16k),
    .prg_32k        (prg_32k),
    .last_bank      (last_bank)
  );

  sbc_mirror_map u_mirror (
    .ctrl (ctrl_q),
    .mode (mirror_mode)
  );

endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
  parameter int PRG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             addr_msb,
  input logic             accept,
  input logic             escape,
  input logic             commit,
  input logic [1:0]       commit_tgt,
  input logic [2:0]       fill_cnt,
  input logic [4:0]       ctrl_q,
  input logic [4:0]       chr_hi4k,
  input logic [PRG_W-1:0] prg_hi16k,
  input logic [PRG_W-1:0] last_bank
);

  AST_LOW_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_msb |-> !accept); // R1

  AST_ESCAPE_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    escape |=> (fill_cnt == 3'd0) && (ctrl_q[3:2] == 2'b11)); // R2

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= 3'd4); // R3

  AST_COMMIT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> fill_cnt == 3'd0); // R4

  AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && commit_tgt == 2'd0) && !escape |=> $stable(ctrl_q)); // R5

  AST_CHR_B_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    commit && commit_tgt == 2'd2 && !ctrl_q[4] |=> $stable(chr_hi4k)); // R8

  AST_HI_FIXED_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    commit && commit_tgt == 2'd3 && ctrl_q[3:2] == 2'b11
      |=> prg_hi16k == $past(last_bank)); // R11

  AST_SINGLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !accept); // R13

endmodule

bind serial_bank_ctrl sbc_checker #(.PRG_W(PRG_W)) u_sbc_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_msb   (cpu_addr[ADDR_W-1]),
  .accept     (accept),
  .escape     (escape),
  .commit     (commit),
  .commit_tgt (commit_tgt),
  .fill_cnt   (fill_cnt),
  .ctrl_q     (ctrl_q),
  .chr_hi4k   (chr_hi4k),
  .prg_hi16k  (prg_hi16k),
  .last_bank  (last_bank)
);

// File: tb/serial_bank_ctrl_bench.sv
module serial_bank_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0;
  logic [7:0]  cpu_wdata = 8'h0;
  logic        cpu_we = 1'b0;
  logic [4:0]  prg_bank_count = 5'd8;
  logic [4:0]  ctrl_q, chr_lo4k, chr_hi4k, chr_8k;
  logic [1:0]  mirror_mode;
  logic [3:0]  prg_lo16k, prg_hi16k;
  logic [2:0]  prg_32k;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  serial_bank_ctrl u_serial_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .prg_bank_count(prg_bank_count), .ctrl_q(ctrl_q),
    .mirror_mode(mirror_mode), .chr_lo4k(chr_lo4k), .chr_hi4k(chr_hi4k),
    .chr_8k(chr_8k), .prg_lo16k(prg_lo16k), .prg_hi16k(prg_hi16k),
    .prg_32k(prg_32k)
  );

  // Behavioural reference model, integers only.
  int m_ctrl, m_clo, m_chi, m_c8, m_plo, m_phi, m_p32, m_sh, m_cnt, m_pwe;

  always @(posedge clk) begin
    int tgt;
    if (!rst_n) begin
      m_ctrl = 28; m_clo = 0; m_chi = 0; m_c8 = 0; m_plo = 0; m_p32 = 0;
      m_phi = (int'(prg_bank_count) - 1) % 16;
      m_sh = 0; m_cnt = 0; m_pwe = 0;
    end else begin
      if (cpu_we && m_pwe == 0 && int'(cpu_addr) >= 32768) begin
        if (cpu_wdata[7]) begin
          m_sh = 0; m_cnt = 0; m_ctrl = m_ctrl | 12;
        end else begin
          m_sh = (m_sh / 2) + 16 * int'(cpu_wdata[0]);
          m_cnt = m_cnt + 1;
          if (m_cnt == 5) begin
            tgt = (int'(cpu_addr) / 8192) % 4;
            if (tgt == 0) m_ctrl = m_sh;
            else if (tgt == 1) begin
              if (m_ctrl / 16 % 2 == 1) m_clo = m_sh;
              else m_c8 = m_sh - (m_sh % 2);
            end else if (tgt == 2) begin
              if (m_ctrl / 16 % 2 == 1) m_chi = m_sh;
            end else begin
              case ((m_ctrl / 4) % 4)
                0, 1: m_p32 = (m_sh % 16) / 2;
                2: begin m_plo = 0; m_phi = m_sh % 16; end
                default: begin m_plo = m_sh % 16; m_phi = (int'(prg_bank_count) - 1) % 16; end
              endcase
            end
            m_sh = 0; m_cnt = 0;
          end
        end
      end
      m_pwe = int'(cpu_we);
    end
  end

  task automatic chk(input string req, input string nm, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, nm, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5", "model ctrl", int'(ctrl_q), m_ctrl);
      chk("R6", "model mirror", int'(mirror_mode), m_ctrl % 4);
      chk("R7", "model chr_lo4k", int'(chr_lo4k), m_clo);
      chk("R7", "model chr_8k", int'(chr_8k), m_c8);
      chk("R8", "model chr_hi4k", int'(chr_hi4k), m_chi);
      chk("R9", "model prg_32k", int'(prg_32k), m_p32);
      chk("R10", "model prg_lo16k", int'(prg_lo16k), m_plo);
      chk("R11", "model prg_hi16k", int'(prg_hi16k), m_phi);
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input int hold);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    repeat (hold - 1) @(negedge clk);
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic load(input logic [15:0] a, input logic [4:0] v, input int hold);
    for (int i = 0; i < 5; i++) wr(a, {7'b0, v[i]}, hold);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    do_reset();
    // Reset state
    chk("R5", "reset ctrl", int'(ctrl_q), 28);
    chk("R6", "reset mirror", int'(mirror_mode), 0);
    chk("R12", "reset prg_hi16k", int'(prg_hi16k), 7);
    chk("R12", "reset prg_lo16k", int'(prg_lo16k), 0);
    chk("R12", "reset chr_8k", int'(chr_8k), 0);

    // Four bits, no commit yet; fifth commits 0x1F
    for (int i = 0; i < 4; i++) wr(16'h8000, 8'h01, 1);
    chk("R3", "no commit before fifth", int'(ctrl_q), 28);
    wr(16'h8000, 8'h01, 1);
    chk("R3", "ctrl after five", int'(ctrl_q), 31);
    chk("R6", "mirror horizontal", int'(mirror_mode), 3);

    load(16'hA000, 5'h15, 1);
    chk("R7", "chr_lo4k split", int'(chr_lo4k), 21);
    chk("R7", "chr_8k untouched", int'(chr_8k), 0);
    load(16'hC000, 5'h0A, 1);
    chk("R8", "chr_hi4k split", int'(chr_hi4k), 10);
    load(16'hE000, 5'h09, 1);
    chk("R11", "mode3 lo", int'(prg_lo16k), 9);
    chk("R11", "mode3 hi last", int'(prg_hi16k), 7);

    load(16'h8000, 5'h08, 1);
    chk("R6", "mirror single low", int'(mirror_mode), 0);
    load(16'hE000, 5'h0C, 1);
    chk("R10", "mode2 lo zero", int'(prg_lo16k), 0);
    chk("R10", "mode2 hi", int'(prg_hi16k), 12);
    load(16'hA000, 5'h13, 1);
    chk("R7", "chr_8k even", int'(chr_8k), 18);
    chk("R7", "chr_lo4k kept", int'(chr_lo4k), 21);
    load(16'hC000, 5'h05, 1);
    chk("R8", "chr_hi4k ignored", int'(chr_hi4k), 10);

    load(16'h8000, 5'h02, 1);
    chk("R6", "mirror vertical", int'(mirror_mode), 2);
    load(16'hE000, 5'h0B, 1);
    chk("R9", "mode0 32k", int'(prg_32k), 5);
    load(16'h8000, 5'h05, 1);
    chk("R6", "mirror single high", int'(mirror_mode), 1);
    load(16'hE000, 5'h06, 1);
    chk("R9", "mode1 32k", int'(prg_32k), 3);

    // Low-address writes inside a sequence (value 0x0E)
    wr(16'h8000, 8'h00, 1); wr(16'h8000, 8'h01, 1); wr(16'h8000, 8'h01, 1);
    wr(16'h6000, 8'h01, 1); wr(16'h7FFF, 8'h81, 1);
    chk("R1", "low escape ignored", int'(ctrl_q), 5);
    wr(16'h8000, 8'h01, 1);
    chk("R1", "low writes not counted", int'(ctrl_q), 5);
    wr(16'h8000, 8'h00, 1);
    chk("R1", "commit after five high", int'(ctrl_q), 14);

    // Escape mid-sequence
    load(16'h8000, 5'h02, 1);
    wr(16'h8000, 8'h01, 1); wr(16'h8000, 8'h01, 1);
    wr(16'h8000, 8'h80, 1);
    chk("R2", "escape sets mode bits", int'(ctrl_q), 14);
    load(16'h8000, 5'h01, 1);
    chk("R2", "fresh sequence after escape", int'(ctrl_q), 1);

    // Destination from fifth write (value 0x07)
    wr(16'h8000, 8'h01, 1); wr(16'h8000, 8'h01, 1);
    wr(16'h8000, 8'h01, 1); wr(16'h8000, 8'h00, 1);
    wr(16'hA000, 8'h00, 1);
    chk("R4", "fifth address picks chr", int'(chr_8k), 6);
    chk("R4", "ctrl untouched", int'(ctrl_q), 1);
    load(16'h8000, 5'h10, 1);
    chk("R4", "restart after commit", int'(ctrl_q), 16);

    // Held strobes
    load(16'h8000, 5'h03, 4);
    chk("R13", "held strobe once", int'(ctrl_q), 3);

    // Reset with a different bank count
    prg_bank_count = 5'd16;
    do_reset();
    chk("R12", "reset hi count16", int'(prg_hi16k), 15);
    chk("R12", "reset chr_lo4k", int'(chr_lo4k), 0);
    load(16'h8000, 5'h0C, 1);
    load(16'hE000, 5'h02, 1);
    chk("R11", "mode3 lo count16", int'(prg_lo16k), 2);
    chk("R11", "mode3 hi count16", int'(prg_hi16k), 15);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule